// File: doc/BRIEF.md
# Symmetric 2D Convolution Filter

This block filters a raster stream of single-plane video samples with a V×H fixed-point kernel. It accepts one sample per clock when `in_valid` is high. The first sample of a frame carries `in_sof`. The frame size is fixed by the `IMG_W` and `IMG_H` parameters. The block keeps the most recent V+1 image rows in a circular row store. Around each output position it reads a window and clamps the coordinates, so samples beyond a frame border repeat the nearest border sample. The output stream has exactly one sample for every input position, in raster order.

The kernel lives in a small coefficient bank. Each coefficient is a two's-complement fixed-point value with `CI` integer bits and `CF` fraction bits, and it is loaded through a simple write port. Three compile-time folds can be enabled: vertical, horizontal and diagonal. With folding on, one stored coefficient serves every position that is symmetric to it, so fewer values need to be loaded. New coefficients collect in a staging bank and move to the working bank when the next frame starts. The accumulated sum is scaled by 2^-CF, rounded in the mode that `rnd_mode` selects, and clamped to the output width.

Top module: `sym_conv2d`

## Requirements
- R1: After reset `out_valid` is low, and the working kernel is 1.0 at the centre tap and 0 elsewhere, so each output sample equals the input sample at the same position.
- R2: A frame gives exactly IMG_W*IMG_H output samples in raster order. `out_sof` is high on the first of them and `out_eol` is high on every sample in column IMG_W-1. The trailing outputs appear without any further input. Samples that arrive before the first `in_sof` are ignored.
- R3: The output at (y,x) is the sum over the kernel of coef(r,c) times the sample at (clamp(y+r-V/2), clamp(x+c-H/2)). Each coordinate is clamped into the frame.
- R4: With vertical folding, position (r,c) uses the stored value of (V-1-r,c) whenever V-1-r < r. Writes to the coefficient address r*H+c of a folded-away row have no effect on the output.
- R5: With horizontal folding, position (r,c) uses (r,H-1-c) whenever H-1-c < c. Writes to folded-away columns have no effect.
- R6: With diagonal folding, applied after the other two folds, a position with row > column uses the coefficient of the transposed position. Writes to those addresses (address 3 for a 3×3 kernel) have no effect.
- R7: With `rnd_mode` = 0 the scaled sum is truncated toward minus infinity.
- R8: With `rnd_mode` = 1 a dropped fraction of one half or more rounds up.
- R9: With `rnd_mode` = 2 a dropped fraction above one half rounds up. A fraction of exactly one half rounds to the nearer even result.
- R10: A rounded result below zero outputs 0, and a result above 2^OUT_W-1 outputs 2^OUT_W-1.
- R11: A coefficient write takes effect at the next accepted `in_sof`. Every sample of a frame uses the kernel that was in force at its start.
- R12: Coefficients are CI+CF-bit two's-complement values, so a set top bit makes the coefficient negative.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input sample present |
| in_sof | input | 1 | Input sample is the first of a frame |
| in_pix | input | IN_W | Input sample |
| coef_we | input | 1 | Coefficient write strobe |
| coef_addr | input | $clog2(V*H) | Kernel position r*H+c |
| coef_data | input | CI+CF | Coefficient value |
| rnd_mode | input | 2 | 0 truncate, 1 half up, 2 half even, 3 truncate |
| out_valid | output | 1 | Output sample present |
| out_sof | output | 1 | First output sample of a frame |
| out_eol | output | 1 | Output sample ends a row |
| out_pix | output | OUT_W | Filtered, rounded, clamped sample |

## Verification
Some properties are checked on every cycle. The sample count per frame may not exceed the frame size. Each `out_eol` must fall on the last column. `out_sof` and `out_eol` are only allowed while `out_valid` is high. Nothing may appear before a frame has started. The arithmetic cannot be checked that way. Border replication, kernel folding, the three rounding modes, saturation and the frame-aligned coefficient switch are only shown by the bench's frames, which compare every output sample against a reference convolution.

// File: rtl/sym_conv2d.sv
module sym_conv2d #(
  parameter int V = 3,
  parameter int H = 3,
  parameter int IN_W = 8,
  parameter int OUT_W = 9,
  parameter int IMG_W = 12,
  parameter int IMG_H = 8,
  parameter int CI = 2,
  parameter int CF = 6,
  parameter bit SIGNED_COEF = 1'b1,
  parameter bit MIRROR_V = 1'b1,
  parameter bit MIRROR_H = 1'b1,
  parameter bit MIRROR_D = 1'b1,
  localparam int CW = CI + CF,
  localparam int NTAP = V * H,
  localparam int AW = $clog2(NTAP)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             in_sof,
  input  logic [IN_W-1:0]  in_pix,
  input  logic             coef_we,
  input  logic [AW-1:0]    coef_addr,
  input  logic [CW-1:0]    coef_data,
  input  logic [1:0]       rnd_mode,
  output logic             out_valid,
  output logic             out_sof,
  output logic             out_eol,
  output logic [OUT_W-1:0] out_pix
);
  localparam int RV = V / 2;
  localparam int RH = H / 2;
  localparam int NS = V + 1;
  localparam int SW = $clog2(NS);
  localparam int XW = $clog2(IMG_W);
  localparam int YW = $clog2(IMG_H + 1);
  localparam int NPIX = IMG_W * IMG_H;
  localparam int PW = $clog2(NPIX + 1);
  localparam int DLY = RV * IMG_W + RH;
  localparam int CTR = RV * H + RH;
  localparam int ACC_W = IN_W + CW + $clog2(NTAP) + 3;
  localparam bit HAS_F = (CF > 0);
  localparam logic [ACC_W-1:0] MASK = (ACC_W'(1) << CF) - ACC_W'(1);
  localparam logic [ACC_W-1:0] HALF = (ACC_W'(1) << CF) >> 1;
  localparam logic signed [ACC_W-1:0] MAXO = (ACC_W'(1) << OUT_W) - ACC_W'(1);

  logic [IN_W-1:0] lbuf [NS][IMG_W];
  logic [CW-1:0]   kpend [NTAP];
  logic [CW-1:0]   kact  [NTAP];
  logic [PW-1:0]   icnt, ocnt;
  logic [XW-1:0]   ix, ox;
  logic [YW-1:0]   iy, oy;
  logic [SW-1:0]   wslot;

  logic signed [ACC_W-1:0] acc, q, qr;
  logic [ACC_W-1:0]        frac;
  logic                    bump;
  logic [OUT_W-1:0]        res;

  wire take = in_valid && (in_sof || (icnt != '0 && icnt < PW'(NPIX)));
  wire emit = (ocnt < PW'(NPIX)) &&
              ((int'(icnt) > int'(ocnt) + DLY) || (icnt == PW'(NPIX)));

  wire [XW-1:0]   wx  = in_sof ? '0 : ix;
  wire [YW-1:0]   wy  = in_sof ? '0 : iy;
  wire [SW-1:0]   wsl = in_sof ? '0 : wslot;

  always_ff @(posedge clk) begin
    if (take) lbuf[wsl][wx] <= in_pix;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      icnt <= '0; ix <= '0; iy <= '0; wslot <= '0;
    end else if (take) begin
      icnt <= in_sof ? PW'(1) : icnt + PW'(1);
      if (wx == XW'(IMG_W - 1)) begin
        ix    <= '0;
        iy    <= wy + YW'(1);
        wslot <= (wsl == SW'(NS - 1)) ? '0 : wsl + SW'(1);
      end else begin
        ix    <= wx + XW'(1);
        iy    <= wy;
        wslot <= wsl;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NTAP; i++) begin
        kpend[i] <= (i == CTR) ? CW'(1) << CF : '0;
        kact[i]  <= (i == CTR) ? CW'(1) << CF : '0;
      end
    end else begin
      if (coef_we && int'(coef_addr) < NTAP) kpend[coef_addr] <= coef_data;
      if (take && in_sof) kact <= kpend;
    end
  end

  always_comb begin
    int yy, xx, sl, rr, cc, t;
    logic signed [IN_W:0]    pv;
    logic signed [CW:0]      cv;
    logic [CW-1:0]           kv;
    logic signed [ACC_W-1:0] prod;
    acc = '0;
    for (int r = 0; r < V; r++) begin
      for (int c = 0; c < H; c++) begin
        yy = int'(oy) + r - RV;
        if (yy < 0) yy = 0;
        if (yy > IMG_H - 1) yy = IMG_H - 1;
        xx = int'(ox) + c - RH;
        if (xx < 0) xx = 0;
        if (xx > IMG_W - 1) xx = IMG_W - 1;
        sl = int'(wslot) - (int'(iy) - yy);
        if (sl < 0) sl = sl + NS;
        rr = r;
        cc = c;
        if (MIRROR_V && rr > V - 1 - rr) rr = V - 1 - rr;
        if (MIRROR_H && cc > H - 1 - cc) cc = H - 1 - cc;
        if (MIRROR_D && rr > cc) begin
          t = rr; rr = cc; cc = t;
        end
        t = rr * H + cc;
        kv = kact[t[AW-1:0]];
        pv = {1'b0, lbuf[sl[SW-1:0]][xx[XW-1:0]]};
        cv = SIGNED_COEF ? {kv[CW-1], kv} : {1'b0, kv};
        prod = ACC_W'(pv) * ACC_W'(cv);
        acc = acc + prod;
      end
    end
  end

  assign q    = acc >>> CF;
  assign frac = acc & MASK;

  always_comb begin
    case (rnd_mode)
      2'd1:    bump = HAS_F && (frac >= HALF);
      2'd2:    bump = HAS_F && ((frac > HALF) || (frac == HALF && q[0]));
      default: bump = 1'b0;
    endcase
  end

  assign qr  = bump ? q + ACC_W'(1) : q;
  assign res = qr[ACC_W-1] ? '0 : (qr > MAXO) ? '1 : qr[OUT_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ocnt <= '0; ox <= '0; oy <= '0;
    end else if (take && in_sof) begin
      ocnt <= '0; ox <= '0; oy <= '0;
    end else if (emit) begin
      ocnt <= ocnt + PW'(1);
      if (ox == XW'(IMG_W - 1)) begin
        ox <= '0;
        oy <= oy + YW'(1);
      end else begin
        ox <= ox + XW'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0; out_sof <= 1'b0; out_eol <= 1'b0; out_pix <= '0;
    end else begin
      out_valid <= emit;
      out_sof   <= emit && (ocnt == '0);
      out_eol   <= emit && (ox == XW'(IMG_W - 1));
      if (emit) out_pix <= res;
    end
  end
endmodule

module sym_conv2d_chk #(
  parameter int IMG_W = 12,
  parameter int IMG_H = 8
) (
  input logic clk,
  input logic rst_n,
  input logic in_valid,
  input logic in_sof,
  input logic out_valid,
  input logic out_sof,
  input logic out_eol
);
  localparam int NPIX = IMG_W * IMG_H;
  logic seen;
  int   col, cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seen <= 1'b0; col <= 0; cnt <= 0;
    end else begin
      if (in_valid && in_sof) seen <= 1'b1;
      if (out_valid) begin
        col <= out_sof ? ((IMG_W == 1) ? 0 : 1) : ((col == IMG_W - 1) ? 0 : col + 1);
        cnt <= out_sof ? 1 : cnt + 1;
      end
    end
  end

  assert_quiet_after_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !out_valid);
  assert_sof_qualified_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_sof || out_eol) |-> out_valid);
  assert_eol_column_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_sof) |-> (out_eol == (col == IMG_W - 1)));
  assert_frame_length_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_sof) |-> (cnt < NPIX));
  assert_no_early_output_R2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> seen);
endmodule

bind sym_conv2d sym_conv2d_chk #(.IMG_W(IMG_W), .IMG_H(IMG_H)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof),
  .out_valid(out_valid), .out_sof(out_sof), .out_eol(out_eol)
);

// File: tb/sim_sym_conv2d.sv
module sim_sym_conv2d;
  localparam int CLK_P = 10;
  localparam int W = 12;
  localparam int HH = 8;
  localparam int NP = W * HH;
  localparam int KV = 3;
  localparam int CF = 6;
  localparam int CW = 8;

  logic clk = 0, rst_n = 0;
  logic in_valid = 0, in_sof = 0;
  logic [7:0] in_pix = 0;
  logic coef_we = 0;
  logic [3:0] coef_addr = 0;
  logic [CW-1:0] coef_data = 0;
  logic [1:0] rnd_mode = 0;
  logic out_valid, out_sof, out_eol;
  logic [8:0] out_pix;

  int checks = 0, errors = 0;
  int img [HH][W];
  int exp_pix [NP];
  int kpend_m [9];
  int kact_m [9];
  int got = 0;
  string cur_tag = "R1";
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  sym_conv2d u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof), .in_pix(in_pix),
    .coef_we(coef_we), .coef_addr(coef_addr), .coef_data(coef_data), .rnd_mode(rnd_mode),
    .out_valid(out_valid), .out_sof(out_sof), .out_eol(out_eol), .out_pix(out_pix)
  );

  task automatic chk(string tag, bit ok, int act, int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (got >= NP) begin
        checks++; errors++;
        $display("FAIL R2 (%s): extra output %0d, actual %0d expected none", cur_tag, got, out_pix);
      end else begin
        checks++;
        if (out_pix != exp_pix[got] || out_sof != (got == 0) || out_eol != (got % W == W - 1)) begin
          errors++;
          $display("FAIL %s pixel %0d: actual %0d sof %0d eol %0d, expected %0d sof %0d eol %0d",
                   cur_tag, got, out_pix, out_sof, out_eol, exp_pix[got], got == 0, got % W == W - 1);
        end
      end
      got++;
    end
  end

  function automatic int canon(int r, int c);
    int rr = r, cc = c, t;
    if (rr > KV - 1 - rr) rr = KV - 1 - rr;
    if (cc > KV - 1 - cc) cc = KV - 1 - cc;
    if (rr > cc) begin t = rr; rr = cc; cc = t; end
    return rr * KV + cc;
  endfunction

  function automatic int clampi(int v, int hi);
    return (v < 0) ? 0 : (v > hi) ? hi : v;
  endfunction

  function automatic int model(int y, int x, int mode);
    longint s = 0, q, fr;
    int k;
    for (int r = 0; r < KV; r++)
      for (int c = 0; c < KV; c++) begin
        k = kact_m[canon(r, c)];
        if (k >= 128) k -= 256;
        s += longint'(k) * img[clampi(y + r - 1, HH - 1)][clampi(x + c - 1, W - 1)];
      end
    q = s >>> CF;
    fr = s - (q <<< CF);
    if (mode == 1 && fr >= 32) q++;
    if (mode == 2 && (fr > 32 || (fr == 32 && (q & 1) == 1))) q++;
    if (q < 0) q = 0;
    if (q > 511) q = 511;
    return int'(q);
  endfunction

  task automatic wcoef(int a, int d);
    @(negedge clk);
    coef_we = 1; coef_addr = 4'(a); coef_data = CW'(d);
    kpend_m[a] = d & 255;
    @(negedge clk);
    coef_we = 0;
  endtask

  task automatic set_kernel(int a0, int a1, int a4);
    wcoef(0, a0); wcoef(1, a1); wcoef(4, a4);
  endtask

  task automatic run_frame(string tag, int mode, int pat, int gap_pct, bit mid_wr);
    int wait_n;
    @(negedge clk);
    rnd_mode = 2'(mode);
    for (int y = 0; y < HH; y++)
      for (int x = 0; x < W; x++)
        case (pat)
          1: img[y][x] = 255;
          2: img[y][x] = ((y * W + x) * 2 + 1) % 256;
          default: img[y][x] = $urandom % 256;
        endcase
    kact_m = kpend_m;
    for (int i = 0; i < NP; i++) exp_pix[i] = model(i / W, i % W, mode);
    got = 0;
    cur_tag = tag;
    for (int i = 0; i < NP; i++) begin
      @(negedge clk);
      coef_we = 0;
      while (($urandom % 100) < gap_pct) begin
        in_valid = 0; in_sof = 0;
        @(negedge clk);
      end
      in_valid = 1; in_sof = (i == 0); in_pix = 8'(img[i / W][i % W]);
      if (mid_wr && (i == 40 || i == 41)) begin
        coef_we = 1; coef_addr = (i == 40) ? 4'd4 : 4'd1;
        coef_data = CW'($urandom % 128);
        kpend_m[coef_addr] = int'(coef_data);
      end
    end
    @(negedge clk);
    in_valid = 0; in_sof = 0; coef_we = 0;
    wait_n = 0;
    while (got < NP && wait_n < 3000) begin @(negedge clk); wait_n++; end
    repeat (8) @(negedge clk);
    chk({"R2 count ", tag}, got == NP, got, NP);
  endtask

  initial begin
    for (int i = 0; i < 9; i++) kpend_m[i] = (i == 4) ? 64 : 0;
    void'($urandom(32'h5eed_c0de));
    repeat (3) @(negedge clk);
    chk("R1 out_valid after reset", out_valid == 0, out_valid, 0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 out_valid idle", out_valid == 0, out_valid, 0);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk); in_valid = 1; in_sof = 0; in_pix = 8'(i);
    end
    @(negedge clk); in_valid = 0;
    got = 0;
    repeat (30) @(negedge clk);
    chk("R2 pre-frame samples ignored", got == 0, got, 0);

    run_frame("R1 identity kernel", 0, 0, 0, 0);
    set_kernel(3, 9, 20);
    run_frame("R3 R7 edge replicate truncate", 0, 0, 30, 0);
    set_kernel(0, 0, 32);
    run_frame("R7 truncate half", 0, 2, 0, 0);
    run_frame("R8 half up directed", 1, 2, 0, 0);
    run_frame("R9 half even directed", 2, 2, 0, 0);
    set_kernel(5, 11, 17);
    run_frame("R8 half up random", 1, 0, 20, 0);
    run_frame("R9 half even random", 2, 0, 20, 0);
    set_kernel(0, 0, 8'hC0);
    run_frame("R10 R12 negative saturates low", 0, 0, 0, 0);
    set_kernel(127, 127, 127);
    run_frame("R10 saturate high", 0, 1, 0, 0);
    set_kernel(8'hF0, 40, 60);
    run_frame("R12 R3 signed mix", 2, 0, 10, 0);
    wcoef(6, 127); wcoef(7, 8'h80);
    run_frame("R4 vertical fold ignores rows", 0, 0, 0, 0);
    wcoef(2, 99); wcoef(5, 8'h90); wcoef(8, 127);
    run_frame("R5 horizontal fold ignores columns", 1, 0, 0, 0);
    wcoef(3, 111);
    run_frame("R6 diagonal fold ignores lower", 2, 0, 0, 0);
    run_frame("R11 mid-frame write deferred", 0, 0, 15, 1);
    run_frame("R11 deferred write applied", 0, 0, 15, 0);
    for (int f = 0; f < 4; f++) begin
      set_kernel($urandom % 256, $urandom % 256, $urandom % 256);
      run_frame("R3 random", $urandom % 3, 0, $urandom % 40, 0);
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule